// File: doc/BRIEF.md
# Polyphase Halfband Rate Converter

This block is a fixed-coefficient 67-tap halfband FIR that changes a sample stream's rate by a factor of two, either down or up. In a halfband response every tap at an even distance from the middle tap is zero, except the middle tap itself. The filter therefore reduces to two branches. The first is a 34-tap branch that holds all the nonzero side taps and folds them in symmetric pairs. The second is a plain delay that carries the middle tap, whose weight is one half. The decimating path and the interpolating path share both branches; only the way samples are routed into them changes.

The stream on `in_data` is either a real signal or one lane of a complex pair. A lane is filtered exactly like a real stream; the mixing stage that feeds or follows the lane lies outside this block. Results leave at full precision as coefficient-scaled integers (one unit equals 2^-19). A stage downstream performs rounding and output formatting. A sample accepted together with `sync` restarts the filter's fill count. In decimation it also fixes which input sample completes each output pair.

Top module: `hbf_halfband`

## Requirements
- R1: `mode[0]` selects the rate change: 0 decimates (codes 00 and 10), 1 interpolates (codes 01 and 11). `mode[1]` changes neither the output values nor their timing.
- R2: The impulse response h[k], k = 0..66, is symmetric about k = 33, where h[33] = 262144 (one half at 2^19 scale). Every other tap with an even distance from 33 is zero. The taps at odd distance d from the middle are: d=1: 166000, 3: -54000, 5: 31000, 7: -21000, 9: 15000, 11: -11200, 13: 8400, 15: -6300, 17: 4700, 19: -3400, 21: 2450, 23: -1700, 25: 1150, 27: -740, 29: 450, 31: -250, 33: 110.
- R3: In decimation, input samples are counted from reset or from the last sync sample, starting at 0. Each odd-numbered sample j produces one output equal to the sum over k of h[k]·x[j-k]. That output is valid for exactly one cycle, two rising edges after the edge that accepted sample j. Outputs never appear on consecutive cycles.
- R4: In decimation, a sample accepted with `sync` high is sample 0: it opens a pair, and the next accepted sample closes that pair.
- R5: In interpolation, with u[2n] = x[n] and u[2n+1] = 0, each input x[n] produces two outputs on consecutive cycles. They are 2·Σ h[k]·u[2n-k] and then 2·Σ h[k]·u[2n+1-k] = x[n-16]·2^19. The first is valid two edges after x[n] is accepted.
- R6: After reset or a sync sample, `out_valid` stays low until the filter has filled. The first output belongs to sample 67 in decimation and to sample 33 in interpolation. Two edges after a sync sample, `out_valid` is low.
- R7: The 40-bit result is exact for all 16-bit inputs, including runs of full-scale values of either sign.
- R8: In interpolation, accepted samples are separated by at least one idle cycle. At that minimum spacing the output stream is continuous and correct.
- R9: During and after reset, `out_valid` is 0 and `out_data` is 0 until the first output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Bit 0: 0 decimate, 1 interpolate; bit 1 marks a complex lane |
| sync | input | 1 | With `in_valid`: restart fill, and in decimation begin a pair |
| in_valid | input | 1 | `in_data` holds a sample this cycle |
| in_data | input | 16 | Signed two's complement input sample |
| out_valid | output | 1 | `out_data` holds a result this cycle |
| out_data | output | 40 | Signed result scaled by 2^19 |

## Verification
On every cycle, the assertions check the cycle-level rules. Decimated outputs are never adjacent. Each first interpolated output is followed by its partner on the next cycle. The output is quiet two edges after a sync sample. Interpolating inputs are spaced apart. A sync sample in decimation is followed by the sample that closes its pair. Only the bench can show the arithmetic: the coefficient values, the symmetric folding, the alignment of the middle tap, and exactness at full scale. It does this by comparing each result against a direct convolution, with zero stuffing for interpolation. The bench's stream scenarios also show the exact fill point and the pairing chosen by sync.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;
  localparam int HB_TAPS   = 67;
  localparam int HB_COEF_W = 20;
  localparam int HB_FRAC   = 19;
  localparam int HB_MID    = (HB_TAPS - 1) / 2;   // middle tap index
  localparam int HB_EVEN_N = HB_MID + 1;          // taps in the folded branch
  localparam int HB_UNIQ_N = HB_EVEN_N / 2;       // distinct side coefficients
  localparam int HB_DLY_N  = HB_MID / 2 + 1;      // depth of the middle-tap delay

  typedef enum logic [1:0] {
    RATE_DOWN      = 2'b00,
    RATE_UP        = 2'b01,
    RATE_DOWN_CPLX = 2'b10,
    RATE_UP_CPLX   = 2'b11
  } hb_mode_e;

  // side coefficient at odd distance off from the middle tap
  function automatic logic signed [HB_COEF_W-1:0] side_coef(input int off);
    case (off)
      1:  return 20'sd166000;
      3:  return -20'sd54000;
      5:  return 20'sd31000;
      7:  return -20'sd21000;
      9:  return 20'sd15000;
      11: return -20'sd11200;
      13: return 20'sd8400;
      15: return -20'sd6300;
      17: return 20'sd4700;
      19: return -20'sd3400;
      21: return 20'sd2450;
      23: return -20'sd1700;
      25: return 20'sd1150;
      27: return -20'sd740;
      29: return 20'sd450;
      31: return -20'sd250;
      33: return 20'sd110;
      default: return '0;
    endcase
  endfunction

  // coefficient for folded pair i (tap 2i and its mirror)
  function automatic logic signed [HB_COEF_W-1:0] pair_coef(input int i);
    return side_coef(HB_MID - 2 * i);
  endfunction

  function automatic logic up_rate(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/hbf_tapline.sv
`timescale 1ns/1ps
module hbf_tapline #(
  parameter int W     = 16,
  parameter int DEPTH = 34
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift_en) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/hbf_evensum.sv
`timescale 1ns/1ps
module hbf_evensum import hbf_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [HB_EVEN_N-1:0][DATA_W-1:0] taps,
  output logic signed [ACC_W-1:0]           sum
);
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + HB_COEF_W;

  function automatic logic signed [PRE_W-1:0] fold(input logic signed [DATA_W-1:0] a,
                                                   input logic signed [DATA_W-1:0] b);
    return PRE_W'(a) + PRE_W'(b);
  endfunction

  logic signed [PROD_W-1:0] prod [HB_UNIQ_N];

  for (genvar g = 0; g < HB_UNIQ_N; g++) begin : g_pair
    localparam logic signed [HB_COEF_W-1:0] CG = pair_coef(g);
    logic signed [PRE_W-1:0] pre;
    assign pre     = fold(taps[g], taps[HB_EVEN_N-1-g]);
    assign prod[g] = PROD_W'(pre) * PROD_W'(CG);
  end

  always_comb begin
    logic signed [ACC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HB_UNIQ_N; i++) acc = acc + ACC_W'(prod[i]);
    sum = acc;
  end
endmodule

// File: rtl/hbf_seq.sv
`timescale 1ns/1ps
module hbf_seq #(
  parameter int FILL_N = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic sync,
  input  logic in_valid,
  output logic push_fold,
  output logic push_dly,
  output logic slot1_q,
  output logic slot1_up_q,
  output logic slot2_q
);
  localparam int CNT_W = $clog2(FILL_N + 1);

  logic             pair_open_q;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             restart, full_d, fire;

  always_comb begin
    restart  = in_valid && sync;
    push_dly = up ? in_valid : (in_valid && (sync || !pair_open_q));
    push_fold = up ? in_valid : (in_valid && !push_dly);
    if (restart)
      fill_d = push_fold ? CNT_W'(1) : '0;
    else if (push_fold && fill_q != CNT_W'(FILL_N))
      fill_d = fill_q + 1'b1;
    else
      fill_d = fill_q;
    full_d = (fill_d == CNT_W'(FILL_N));
    fire   = push_fold && full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_open_q <= 1'b0;
      fill_q      <= '0;
      slot1_q     <= 1'b0;
      slot1_up_q  <= 1'b0;
      slot2_q     <= 1'b0;
    end else begin
      if (in_valid) pair_open_q <= up ? 1'b0 : push_dly;
      fill_q     <= fill_d;
      slot1_q    <= fire;
      slot1_up_q <= fire && up;
      slot2_q    <= slot1_up_q;
    end
  end

  // R8: interpolating inputs need a free cycle for the second output
  a_r8_up_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (up && in_valid) |=> !in_valid);

  // R4: after a sync sample in decimation, the next sample closes the pair
  a_r4_sync_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && in_valid && sync) |=> (!(in_valid && !sync && !up) || push_fold));
endmodule

// File: rtl/hbf_halfband.sv
`timescale 1ns/1ps
module hbf_halfband import hbf_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              sync,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);
  logic up;
  logic push_fold, push_dly;
  logic slot1_q, slot1_up_q, slot2_q;
  logic [HB_EVEN_N-1:0][DATA_W-1:0] fold_taps;
  logic [HB_DLY_N-1:0][DATA_W-1:0]  dly_taps;
  logic signed [ACC_W-1:0] fold_sum;
  logic signed [ACC_W-1:0] down_word, up_first, up_second;

  function automatic logic signed [ACC_W-1:0] mid_term(input logic signed [DATA_W-1:0] x,
                                                       input int sh);
    return ACC_W'(x) <<< sh;
  endfunction

  assign up = up_rate(mode);

  hbf_seq #(.FILL_N(HB_EVEN_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .up(up), .sync(sync), .in_valid(in_valid),
    .push_fold(push_fold), .push_dly(push_dly),
    .slot1_q(slot1_q), .slot1_up_q(slot1_up_q), .slot2_q(slot2_q)
  );

  hbf_tapline #(.W(DATA_W), .DEPTH(HB_EVEN_N)) u_fold_line (
    .clk(clk), .rst_n(rst_n), .shift_en(push_fold), .din(in_data), .taps(fold_taps)
  );

  hbf_tapline #(.W(DATA_W), .DEPTH(HB_DLY_N)) u_dly_line (
    .clk(clk), .rst_n(rst_n), .shift_en(push_dly), .din(in_data), .taps(dly_taps)
  );

  hbf_evensum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_evensum (
    .taps(fold_taps), .sum(fold_sum)
  );

  always_comb begin
    down_word = fold_sum + mid_term(dly_taps[HB_DLY_N-1], HB_FRAC - 1);
    up_first  = fold_sum <<< 1;
    up_second = mid_term(dly_taps[HB_DLY_N-1], HB_FRAC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (slot1_q) begin
      out_valid <= 1'b1;
      out_data  <= slot1_up_q ? up_first : down_word;
    end else if (slot2_q) begin
      out_valid <= 1'b1;
      out_data  <= up_second;
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R3: decimated results are never adjacent
  a_r3_down_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode[0] && $stable(mode)) |=> !out_valid);

  // R5: a first interpolated result is followed by its partner
  a_r5_up_pair: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_up_q |=> out_valid ##1 out_valid);

  // R6: quiet output two edges after a restart
  a_r6_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sync) |=> ##1 !out_valid);

  // R8: the two output slots never collide
  a_r8_slots_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot1_q && slot2_q));
endmodule

// File: tb/hbf_halfband_tb.sv
`timescale 1ns/1ps
module hbf_halfband_tb;
  localparam int DW = 16;
  localparam int AW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sync = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [AW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int s = 0;
  int hist [0:4095];
  bit done = 1'b0;

  longint exp_val[$];
  int     exp_cyc[$];
  string  exp_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hbf_halfband u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sync(sync),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // impulse response restated by distance from the middle
  function automatic longint tap_h(input int k);
    int d, a;
    d = k - 33;
    a = (d < 0) ? -d : d;
    if (d == 0) return 262144;
    if (a % 2 == 0) return 0;
    case (a)
      33: return 110;     31: return -250;    29: return 450;
      27: return -740;    25: return 1150;    23: return -1700;
      21: return 2450;    19: return -3400;   17: return 4700;
      15: return -6300;   13: return 8400;    11: return -11200;
      9:  return 15000;   7:  return -21000;  5:  return 31000;
      3:  return -54000;  default: return 166000;
    endcase
  endfunction

  function automatic longint down_model(input int j);
    longint acc = 0;
    for (int k = 0; k < 67; k++) acc += tap_h(k) * longint'(hist[j-k]);
    return acc;
  endfunction

  function automatic longint up_model(input int n, input int ph);
    longint acc = 0;
    int t = 2 * n + ph;
    for (int k = 0; k < 67; k++) begin
      int m = t - k;
      if (m >= 0 && (m % 2) == 0) acc += tap_h(k) * longint'(hist[m/2]);
    end
    return 2 * acc;
  endfunction

  task automatic expect_out(input longint v, input int c, input string tag);
    exp_val.push_back(v); exp_cyc.push_back(c); exp_tag.push_back(tag);
  endtask

  task automatic send(input int x, input bit sy, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(x); sync = sy;
    @(posedge clk); #1;
    in_valid = 1'b0; sync = 1'b0;
    if (sy) s = 0;
    hist[s] = x;
    if (!mode[0]) begin
      if ((s % 2) == 1 && s >= 67)
        expect_out(down_model(s), cyc + 1, (s == 67) ? "R6" : tag);
    end else if (s >= 33) begin
      expect_out(up_model(s, 0), cyc + 1, (s == 33) ? "R6" : tag);
      expect_out(up_model(s, 1), cyc + 2, tag);
    end
    if (s < 4095) s++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic drain(input string tag);
    idle(6);
    @(negedge clk);
    checks++;
    if (exp_cyc.size() != 0) begin
      errors++;
      $display("FAIL %s pending outputs actual=%0d expected=0", tag, exp_cyc.size());
      exp_val.delete(); exp_cyc.delete(); exp_tag.delete();
    end
  endtask

  // output monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        longint got;
        got = longint'($signed(out_data));
        checks++;
        if (!out_valid || got != exp_val[0]) begin
          errors++;
          $display("FAIL %s cycle %0d actual valid=%0b data=%0d expected valid=1 data=%0d",
                   exp_tag[0], cyc, out_valid, got, exp_val[0]);
        end
        void'(exp_val.pop_front()); void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
      end else if (out_valid) begin
        checks++;
        errors++;
        $display("FAIL R6 cycle %0d unexpected actual valid=1 data=%0d expected valid=0",
                 cyc, longint'($signed(out_data)));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R3 timeout actual cycles=%0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    // R9: reset state
    idle(3);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R9 in reset actual valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
    end
    rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R9 after reset actual valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
    end

    // R3: decimation from reset, random data and gaps
    mode = 2'b00;
    for (int i = 0; i < 200; i++) begin
      send(rnd16(), 1'b0, "R3");
      idle($urandom_range(0, 2));
    end
    drain("R3");

    // R4: sync on a fresh pair boundary, then a dense stream
    send(rnd16(), 1'b1, "R4");
    for (int i = 0; i < 150; i++) send(rnd16(), 1'b0, "R4");
    drain("R4");

    // R2: impulse exposes the coefficients
    send(0, 1'b1, "R2");
    for (int i = 0; i < 69; i++) send(0, 1'b0, "R2");
    send(16384, 1'b0, "R2");
    for (int i = 0; i < 80; i++) send(0, 1'b0, "R2");
    drain("R2");

    // R1: complex-lane decimation code behaves like plain decimation
    idle(4);
    mode = 2'b10;
    send(rnd16(), 1'b1, "R1");
    for (int i = 0; i < 150; i++) begin
      send(rnd16(), 1'b0, "R1");
      idle($urandom_range(0, 1));
    end
    drain("R1");

    // R7: full-scale extremes in decimation
    mode = 2'b00;
    send(-32768, 1'b1, "R7");
    for (int i = 0; i < 90; i++) send(-32768, 1'b0, "R7");
    for (int i = 0; i < 90; i++) send(($urandom_range(0, 1) == 1) ? 32767 : -32768, 1'b0, "R7");
    drain("R7");

    // R5: interpolation with random gaps
    idle(4);
    mode = 2'b01;
    send(rnd16(), 1'b1, "R5");
    for (int i = 0; i < 120; i++) begin
      idle($urandom_range(1, 3));
      send(rnd16(), 1'b0, "R5");
    end
    drain("R5");

    // R8: interpolation at the minimum spacing, impulse then random
    send(0, 1'b1, "R8");
    for (int i = 0; i < 40; i++) begin idle(1); send(0, 1'b0, "R8"); end
    idle(1); send(20000, 1'b0, "R8");
    for (int i = 0; i < 60; i++) begin idle(1); send(rnd16(), 1'b0, "R8"); end
    drain("R8");

    // R1: complex-lane interpolation code, then R6 restart mid-stream
    mode = 2'b11;
    send(rnd16(), 1'b1, "R1");
    for (int i = 0; i < 60; i++) begin idle(1); send(rnd16(), 1'b0, "R1"); end
    idle(1);
    send(rnd16(), 1'b1, "R6");
    for (int i = 0; i < 50; i++) begin idle(1); send(rnd16(), 1'b0, "R6"); end
    drain("R6");

    // R7: full-scale in interpolation
    mode = 2'b01;
    send(32767, 1'b1, "R7");
    for (int i = 0; i < 70; i++) begin
      idle(1);
      send(($urandom_range(0, 1) == 1) ? 32767 : -32768, 1'b0, "R7");
    end
    drain("R7");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule